// File: doc/BRIEF.md
# Counter Enable Set/Clear Register

This block holds the enable bits for a bank of up to sixteen auxiliary event counters. Software reaches the bits through a simple register bus with read and write strobes and a view select. One view sets bits by writing ones, another clears bits by writing ones, and a third, wider view also clears by writing ones but places the same enable state in the upper half of a 64-bit word. Every view reads back the same shared enable state.

A configuration input gives the number of implemented counters and a per-counter implemented mask. An enable whose counter is not available reads as zero and ignores writes. A configuration with zero counter groups, or the reserved view code, makes an access undefined: it is flagged and has no effect. The registered enable vector drives the counters.

Top module: `cen_enable_regs`

## Requirements
- R1: After reset every enable bit is 0, so `ctr_enable` is 0 and every read returns 0.
- R2: A write through the set view (`acc_view` = 0) sets enable n for each write-data bit n in 15:0 that is 1. Bits written as 0 leave their enable unchanged.
- R3: A write through the clear view (`acc_view` = 1) clears enable n for each write-data bit n in 15:0 that is 1. Bits written as 0 leave their enable unchanged.
- R4: A read through the set view or the clear view returns the available enable state in bits 15:0, with bits 63:16 at 0.
- R5: The wide view (`acc_view` = 2) reads the available enable state at bits 47:32, with all other bits 0. A write through it clears enable n when write-data bit 32+n is 1, and it ignores write-data bits 31:0 and 63:48.
- R6: An enable whose index is greater than or equal to `cfg_num_ctr` reads as 0, and writes to it are ignored.
- R7: An enable whose `cfg_impl_mask` bit is 0 reads as 0, and writes to it are ignored, whatever `cfg_num_ctr` says.
- R8: When `cfg_num_groups` is 0, or `acc_view` is 3, a strobed access raises `acc_undef` in the same cycle, returns read data 0 and changes no enable.
- R9: `ctr_enable` is registered. It changes only on the clock edge that ends the write strobe cycle, and it always equals the stored enable state.
- R10: `acc_rdata` is combinational from the current state and is 0 whenever `acc_rd` is low.
- R11: A read and a write in the same cycle return the state from before the write.
- R12: A stored enable whose counter stops being available is cleared on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous counter-unit reset |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_view | input | 2 | View select: 0 set, 1 clear, 2 wide clear, 3 reserved |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data, valid while `acc_rd` is high |
| acc_undef | output | 1 | Access is undefined and has no effect |
| cfg_num_ctr | input | 5 | Number of implemented counters, 0 to 16 |
| cfg_impl_mask | input | 16 | Per-counter implemented flag |
| cfg_num_groups | input | 4 | Number of counter groups; 0 makes accesses undefined |
| ctr_enable | output | 16 | Registered enable vector to the counters |

## Verification
The hardest situation to reach is the configuration shrinking under enables that are already stored. The state must then vanish from reads at once, be cleared at the next edge, and stay clear when the configuration grows back. The stimulus first sets every bit and then lowers `cfg_num_ctr` and clears mask bits between accesses. It then sweeps random configurations, views and strobes. The behavioural model is compared with `ctr_enable` and with the read data on every clock, so a bit that wrongly survives shows up in the first idle cycle that follows.

// File: rtl/cen_pkg.sv
package cen_pkg;

  typedef enum logic [1:0] {
    VIEW_SET      = 2'd0,
    VIEW_CLR      = 2'd1,
    VIEW_CLR_WIDE = 2'd2,
    VIEW_RSVD     = 2'd3
  } cen_view_e;

  function automatic logic view_legal(input cen_view_e v);
    return v != VIEW_RSVD;
  endfunction

  function automatic logic view_clears(input cen_view_e v);
    return (v == VIEW_CLR) || (v == VIEW_CLR_WIDE);
  endfunction

endpackage

// File: rtl/cen_avail_mask.sv
module cen_avail_mask #(
  parameter int NCTR = 16,
  parameter int CNTW = 5
) (
  input  logic [CNTW-1:0] num_ctr,
  input  logic [NCTR-1:0] impl_mask,
  output logic [NCTR-1:0] avail
);

  for (genvar g = 0; g < NCTR; g++) begin : g_bit
    localparam logic [CNTW-1:0] IDX = CNTW'(g);
    assign avail[g] = impl_mask[g] && (IDX < num_ctr);
  end

endmodule

// File: rtl/cen_access_decode.sv
module cen_access_decode
  import cen_pkg::*;
#(
  parameter int NCTR     = 16,
  parameter int DW       = 64,
  parameter int WIDE_LSB = 32,
  parameter int GRPW     = 4
) (
  input  logic            acc_rd,
  input  logic            acc_wr,
  input  logic [1:0]      acc_view,
  input  logic [DW-1:0]   acc_wdata,
  input  logic [GRPW-1:0] num_groups,
  output logic            undef,
  output logic            rd_ok,
  output logic [NCTR-1:0] set_bits,
  output logic [NCTR-1:0] clr_bits
);

  cen_view_e       view;
  logic            wr_ok;
  logic [NCTR-1:0] field;

  function automatic logic [NCTR-1:0] pick_field(input cen_view_e v,
                                                  input logic [DW-1:0] d);
    if (v == VIEW_CLR_WIDE) return d[WIDE_LSB +: NCTR];
    return d[NCTR-1:0];
  endfunction

  always_comb begin
    view     = cen_view_e'(acc_view);
    undef    = (acc_rd || acc_wr) && ((num_groups == '0) || !view_legal(view));
    rd_ok    = acc_rd && !undef;
    wr_ok    = acc_wr && !undef;
    field    = pick_field(view, acc_wdata);
    set_bits = (wr_ok && view == VIEW_SET) ? field : '0;
    clr_bits = (wr_ok && view_clears(view)) ? field : '0;
  end

endmodule

// File: rtl/cen_enable_bank.sv
module cen_enable_bank #(
  parameter int NCTR = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCTR-1:0] set_bits,
  input  logic [NCTR-1:0] clr_bits,
  input  logic [NCTR-1:0] avail,
  output logic [NCTR-1:0] state
);

  for (genvar g = 0; g < NCTR; g++) begin : g_flop
    always_ff @(posedge clk) begin
      if (!rst_n)              state[g] <= 1'b0;
      else if (!avail[g])      state[g] <= 1'b0;
      else if (clr_bits[g])    state[g] <= 1'b0;
      else if (set_bits[g])    state[g] <= 1'b1;
    end
  end

  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_bits) |=> ((state & $past(set_bits & avail & ~clr_bits)) ==
                     $past(set_bits & avail & ~clr_bits)));

  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((state & ~$past(state | set_bits)) == '0));

  a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_bits) |=> ((state & $past(clr_bits)) == '0));

  a_r12_subset_of_avail: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((state & ~$past(avail)) == '0));

endmodule

// File: rtl/cen_read_mux.sv
module cen_read_mux
  import cen_pkg::*;
#(
  parameter int NCTR     = 16,
  parameter int DW       = 64,
  parameter int WIDE_LSB = 32
) (
  input  logic            rd_ok,
  input  logic [1:0]      acc_view,
  input  logic [NCTR-1:0] state,
  input  logic [NCTR-1:0] avail,
  output logic [DW-1:0]   rdata
);

  function automatic logic [DW-1:0] place(input cen_view_e v,
                                          input logic [NCTR-1:0] s);
    logic [DW-1:0] w;
    w = '0;
    if (v == VIEW_CLR_WIDE) w[WIDE_LSB +: NCTR] = s;
    else                    w[NCTR-1:0] = s;
    return w;
  endfunction

  always_comb begin
    rdata = rd_ok ? place(cen_view_e'(acc_view), state & avail) : '0;
  end

endmodule

// File: rtl/cen_enable_regs.sv
module cen_enable_regs
  import cen_pkg::*;
#(
  parameter int NCTR     = 16,
  parameter int DW       = 64,
  parameter int WIDE_LSB = 32,
  parameter int GRPW     = 4,
  localparam int CNTW    = $clog2(NCTR + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_rd,
  input  logic            acc_wr,
  input  logic [1:0]      acc_view,
  input  logic [DW-1:0]   acc_wdata,
  output logic [DW-1:0]   acc_rdata,
  output logic            acc_undef,
  input  logic [CNTW-1:0] cfg_num_ctr,
  input  logic [NCTR-1:0] cfg_impl_mask,
  input  logic [GRPW-1:0] cfg_num_groups,
  output logic [NCTR-1:0] ctr_enable
);

  logic [NCTR-1:0] avail;
  logic [NCTR-1:0] set_bits;
  logic [NCTR-1:0] clr_bits;
  logic [NCTR-1:0] state;
  logic            rd_ok;

  cen_avail_mask #(.NCTR(NCTR), .CNTW(CNTW)) u_avail (
    .num_ctr   (cfg_num_ctr),
    .impl_mask (cfg_impl_mask),
    .avail     (avail)
  );

  cen_access_decode #(.NCTR(NCTR), .DW(DW), .WIDE_LSB(WIDE_LSB), .GRPW(GRPW)) u_dec (
    .acc_rd     (acc_rd),
    .acc_wr     (acc_wr),
    .acc_view   (acc_view),
    .acc_wdata  (acc_wdata),
    .num_groups (cfg_num_groups),
    .undef      (acc_undef),
    .rd_ok      (rd_ok),
    .set_bits   (set_bits),
    .clr_bits   (clr_bits)
  );

  cen_enable_bank #(.NCTR(NCTR)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (set_bits),
    .clr_bits (clr_bits),
    .avail    (avail),
    .state    (state)
  );

  cen_read_mux #(.NCTR(NCTR), .DW(DW), .WIDE_LSB(WIDE_LSB)) u_rd (
    .rd_ok    (rd_ok),
    .acc_view (acc_view),
    .state    (state),
    .avail    (avail),
    .rdata    (acc_rdata)
  );

  assign ctr_enable = state;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (ctr_enable == '0));

  a_r4_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_view != 2'd2) |-> (acc_rdata[DW-1:NCTR] == '0));

  a_r8_undef_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acc_undef |-> (acc_rdata == '0));

  a_r8_undef_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    acc_undef |=> ((ctr_enable & ~$past(ctr_enable)) == '0));

  a_r9_quiet_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> ((ctr_enable & ~$past(ctr_enable)) == '0));

  a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |-> (acc_rdata == '0));

endmodule

// File: tb/test_cen_enable_regs.sv
module test_cen_enable_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_rd = 1'b0;
  logic        acc_wr = 1'b0;
  logic [1:0]  acc_view = 2'd0;
  logic [63:0] acc_wdata = '0;
  logic [63:0] acc_rdata;
  logic        acc_undef;
  logic [4:0]  cfg_num_ctr = 5'd16;
  logic [15:0] cfg_impl_mask = 16'hFFFF;
  logic [3:0]  cfg_num_groups = 4'd1;
  logic [15:0] ctr_enable;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cen_enable_regs i_cen_enable_regs (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_view(acc_view), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_undef(acc_undef), .cfg_num_ctr(cfg_num_ctr),
    .cfg_impl_mask(cfg_impl_mask), .cfg_num_groups(cfg_num_groups),
    .ctr_enable(ctr_enable)
  );

  // Behavioural reference
  logic [15:0] m_en = '0;

  function automatic logic [15:0] m_avail();
    logic [15:0] a = '0;
    for (int i = 0; i < 16; i++)
      if (cfg_impl_mask[i] == 1'b1 && i < int'(cfg_num_ctr)) a[i] = 1'b1;
    return a;
  endfunction

  function automatic bit m_undef();
    return (acc_rd || acc_wr) && (cfg_num_groups == 0 || acc_view == 2'd3);
  endfunction

  function automatic logic [63:0] m_rdata();
    logic [63:0] r = '0;
    if (acc_rd && !m_undef()) begin
      if (acc_view == 2'd2) r[47:32] = m_en & m_avail();
      else                  r[15:0]  = m_en & m_avail();
    end
    return r;
  endfunction

  always @(posedge clk) begin
    logic [15:0] nx;
    nx = m_en;
    if (!rst_n) nx = '0;
    else begin
      if (acc_wr && !m_undef()) begin
        case (acc_view)
          2'd0: nx = nx | acc_wdata[15:0];
          2'd1: nx = nx & ~acc_wdata[15:0];
          2'd2: nx = nx & ~acc_wdata[47:32];
          default: ;
        endcase
      end
      nx = nx & m_avail();
    end
    m_en <= nx;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // R9: registered output compared on every clock
  always @(negedge clk) begin
    if (rst_n && !done) chk("R9", {48'b0, ctr_enable}, {48'b0, m_en});
  end

  task automatic access(input string tag, input bit rd, input bit wr,
                        input logic [1:0] view, input logic [63:0] wd);
    @(negedge clk);
    acc_rd = rd; acc_wr = wr; acc_view = view; acc_wdata = wd;
    #1;
    chk(tag, acc_rdata, m_rdata());
    chk(tag, {63'b0, acc_undef}, {63'b0, m_undef()});
    chk("R9", {48'b0, ctr_enable}, {48'b0, m_en});
    @(posedge clk);
    #1;
    acc_rd = 0; acc_wr = 0;
  endtask

  task automatic rd_view(input string tag, input logic [1:0] view, input logic [63:0] exp);
    @(negedge clk);
    acc_rd = 1; acc_wr = 0; acc_view = view;
    #1;
    chk(tag, acc_rdata, exp);
    @(posedge clk);
    #1;
    acc_rd = 0;
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {48'b0, ctr_enable}, 64'h0);
    @(negedge clk); rst_n = 1;
    rd_view("R1", 2'd0, 64'h0);

    access("R2", 0, 1, 2'd0, 64'hFFFF_0000_0000_F0F0);
    rd_view("R2", 2'd0, 64'h0000_0000_0000_F0F0);
    rd_view("R4", 2'd1, 64'h0000_0000_0000_F0F0);
    access("R2", 0, 1, 2'd0, 64'h0);
    rd_view("R2", 2'd0, 64'h0000_0000_0000_F0F0);

    access("R3", 0, 1, 2'd1, 64'hFFFF_FFFF_FFFF_0030);
    rd_view("R3", 2'd1, 64'h0000_0000_0000_F0C0);

    rd_view("R5", 2'd2, 64'h0000_F0C0_0000_0000);
    access("R5", 0, 1, 2'd2, 64'hFFFF_0000_FFFF_FFFF);
    rd_view("R5", 2'd0, 64'h0000_0000_0000_F0C0);
    access("R5", 0, 1, 2'd2, 64'h0000_0040_0000_0000);
    rd_view("R5", 2'd0, 64'h0000_0000_0000_F080);

    access("R11", 1, 1, 2'd0, 64'h0000_0000_0000_000F);
    rd_view("R11", 2'd0, 64'h0000_0000_0000_F08F);

    access("R2", 0, 1, 2'd0, 64'hFFFF);
    @(negedge clk); cfg_num_ctr = 5'd8;
    rd_view("R6", 2'd0, 64'h0000_0000_0000_00FF);
    chk("R12", {48'b0, ctr_enable}, 64'h00FF);
    access("R6", 0, 1, 2'd0, 64'hFFFF);
    @(negedge clk); cfg_num_ctr = 5'd16;
    rd_view("R12", 2'd0, 64'h0000_0000_0000_00FF);

    @(negedge clk); cfg_impl_mask = 16'hFFF0;
    access("R7", 0, 1, 2'd0, 64'hFFFF);
    rd_view("R7", 2'd0, 64'h0000_0000_0000_FFF0);

    @(negedge clk); cfg_num_groups = 4'd0;
    access("R8", 1, 1, 2'd1, 64'hFFFF);
    rd_view("R8", 2'd0, 64'h0);
    @(negedge clk); cfg_num_groups = 4'd2;
    access("R8", 1, 1, 2'd3, 64'hFFFF);
    rd_view("R8", 2'd0, 64'h0000_0000_0000_FFF0);

    @(negedge clk); acc_view = 2'd0; #1;
    chk("R10", acc_rdata, 64'h0);

    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) cfg_num_ctr = 5'($urandom_range(0, 16));
      if ($urandom_range(0, 7) == 0) cfg_impl_mask = 16'($urandom);
      if ($urandom_range(0, 15) == 0) cfg_num_groups = 4'($urandom_range(0, 2));
      access("R4", 1'($urandom), 1'($urandom), 2'($urandom),
             {32'($urandom), 32'($urandom)});
    end

    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule